// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block takes one asynchronous serial line and turns it into received characters. The line rests high. A falling edge, taken after a two-flop synchronizer, marks a possible start bit. The block then counts pulses of an oversample enable, which runs at 16 or 8 times the bit rate, and samples the start bit and every later bit at its centre.

The frame format is chosen at run time: 7 or 8 data bits arriving least significant bit first, an optional even or odd parity bit, and one or two stop bits. Each completed character goes into a 16-entry first-word-fall-through queue, together with its own framing-error and parity-error flags. A consumer reads the queue through a single pop strobe and watches the fill level.

A character that finds the queue full is dropped and raises a sticky overrun flag. Baud-rate generation and any register access belong to the surrounding logic.

Top module: `rx_os_top`

## Requirements
- R1: After reset, `empty_o` is 1, `level_o` is 0 and `ovr_o` is 0.
- R2: A high-to-low transition of the synchronized line starts a frame. The start bit is sampled at its midpoint, which is the 8th tick after the edge in 16x mode and the 4th tick in 8x mode. If the line is high at that sample, the frame is abandoned and nothing is stored.
- R3: With `os8_i`=0, consecutive bit samples are 16 ticks apart. With `os8_i`=1, they are 8 ticks apart.
- R4: Data bits arrive least significant bit first. With `len7_i`=1, seven bits are received and bit 7 of the stored byte is 0. With `len7_i`=0, eight bits are received.
- R5: With `par_en_i`=1, one parity bit follows the data. With `par_odd_i`=1, the data ones plus the parity bit must be odd; with `par_odd_i`=0, they must be even. A mismatch stores `pe_o`=1 with that character. With `par_en_i`=0, `pe_o` is stored as 0.
- R6: With `stop2_i`=1, two stop bits are sampled; with `stop2_i`=0, one is sampled. If any sampled stop bit is low, `fe_o`=1 is stored with the character, and the character is still stored.
- R7: The queue holds 16 entries, and `data_o`/`fe_o`/`pe_o` show the oldest entry. `rd_i` removes that entry when `empty_o` is 0. `rd_i` while the queue is empty has no effect.
- R8: A character completed while the queue holds 16 entries, with no pop in the same cycle, is discarded and sets `ovr_o`. `ovr_o` stays set until `clr_ovr_i` is pulsed; a set in the same cycle wins over the clear.
- R9: A character completed in the same cycle as a pop from a full queue is accepted. The level stays 16 and `ovr_o` is not set.
- R10: The frame configuration inputs are captured when the start edge is detected. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | Oversample enable, one clock wide |
| os8_i | input | 1 | 1: 8x oversampling, 0: 16x |
| len7_i | input | 1 | 1: 7 data bits, 0: 8 data bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1: odd parity, 0: even |
| stop2_i | input | 1 | 1: two stop bits |
| rd_i | input | 1 | Pop the oldest entry |
| clr_ovr_i | input | 1 | Clear the overrun flag |
| data_o | output | 8 | Oldest received byte |
| fe_o | output | 1 | Framing error of oldest entry |
| pe_o | output | 1 | Parity error of oldest entry |
| empty_o | output | 1 | Queue empty |
| level_o | output | 5 | Number of stored entries |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The collision that matters is a character completing in the very cycle the consumer pops, most sharply when the queue is full, where the wrong order of full test and pop would drop the character and raise overrun. The bench fills the queue to 16 entries. It then sends one more frame and places a single-cycle pop on the clock edge where that character enters the queue. That edge is counted from the tick-aligned start edge using the two synchronizer stages, the tick spacing and the one-cycle push register. The result is judged by the level staying 16, by overrun staying clear, and by all queued bytes draining in order with the new byte last.

// File: rtl/rx_os_pkg.sv
package rx_os_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       fe;
    logic       pe;
  } rx_ent_t;

  typedef struct packed {
    logic os8;
    logic len7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } rx_cfg_t;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_st_e;
endpackage

// File: rtl/rx_os_sync.sv
module rx_os_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign q_o    = sh_q[STAGES-1];
  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/rx_os_frame.sv
module rx_os_frame
  import rx_os_pkg::*;
#(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    rxd_i,
  input  logic    fall_i,
  input  rx_cfg_t cfg_i,
  output logic    push_o,
  output rx_ent_t ent_o
);
  localparam int CW = $clog2(OS_HI);
  localparam logic [CW-1:0] HI_FULL = CW'(OS_HI - 1);
  localparam logic [CW-1:0] LO_FULL = CW'(OS_LO - 1);
  localparam logic [CW-1:0] HI_MID  = CW'(OS_HI / 2 - 1);
  localparam logic [CW-1:0] LO_MID  = CW'(OS_LO / 2 - 1);

  rx_st_e        st_q;
  rx_cfg_t       cfg_q;
  logic [CW-1:0] cnt_q, lim;
  logic [7:0]    sh_q;
  logic [2:0]    idx_q, last_idx;
  logic          par_q, fe_q, pe_q, push_q, fe_n;
  rx_ent_t       ent_q;

  always_comb begin
    if (st_q == ST_START) lim = cfg_q.os8 ? LO_MID : HI_MID;
    else                  lim = cfg_q.os8 ? LO_FULL : HI_FULL;
    last_idx = cfg_q.len7 ? 3'd6 : 3'd7;
    fe_n     = fe_q | ~rxd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cfg_q <= '0; cnt_q <= '0; sh_q <= '0; idx_q <= '0;
      par_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0; push_q <= 1'b0; ent_q <= '0;
    end else begin
      push_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (fall_i) begin
          st_q  <= ST_START;
          cnt_q <= '0;
          cfg_q <= cfg_i;  // frame format frozen at start edge
        end
      end else if (tick_i) begin
        if (cnt_q != lim) cnt_q <= cnt_q + 1'b1;
        else begin
          cnt_q <= '0;
          unique case (st_q)
            ST_START: begin
              st_q  <= rxd_i ? ST_IDLE : ST_DATA;  // high at midpoint: glitch
              idx_q <= '0; par_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0;
            end
            ST_DATA: begin
              sh_q  <= {rxd_i, sh_q[7:1]};
              par_q <= par_q ^ rxd_i;
              if (idx_q == last_idx) begin
                idx_q <= '0;
                st_q  <= cfg_q.par_en ? ST_PAR : ST_STOP;
              end else idx_q <= idx_q + 1'b1;
            end
            ST_PAR: begin
              pe_q <= par_q ^ rxd_i ^ cfg_q.par_odd;
              st_q <= ST_STOP;
            end
            ST_STOP: begin
              if (cfg_q.stop2 && idx_q == 3'd0) begin
                idx_q <= 3'd1;
                fe_q  <= fe_n;
              end else begin
                st_q       <= ST_IDLE;
                push_q     <= 1'b1;
                ent_q.data <= cfg_q.len7 ? {1'b0, sh_q[7:1]} : sh_q;
                ent_q.fe   <= fe_n;
                ent_q.pe   <= pe_q;
              end
            end
            default: st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign push_o = push_q;
  assign ent_o  = ent_q;
endmodule

// File: rtl/rx_os_fifo.sv
module rx_os_fifo
  import rx_os_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rx_ent_t       ent_i,
  input  logic          pop_i,
  input  logic          clr_ovr_i,
  output rx_ent_t       head_o,
  output logic [LW-1:0] level_o,
  output logic          ovr_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rx_ent_t       mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          full, pop_ok, push_ok, ovr_q;

  assign full    = (cnt_q == LW'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign push_ok = push_i && (!full || pop_ok);  // pop frees a slot in the same cycle

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= ent_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; ovr_q <= 1'b0;
    end else begin
      if (push_ok) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      if (push_i && !push_ok) ovr_q <= 1'b1;
      else if (clr_ovr_i)     ovr_q <= 1'b0;
    end
  end

  assign head_o  = mem_q[rp_q];
  assign level_o = cnt_q;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/rx_os_top.sv
module rx_os_top
  import rx_os_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OS_HI      = 16,
  parameter int OS_LO      = 8,
  parameter int SYNC_STG   = 2,
  parameter int LW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  input  logic          tick_i,
  input  logic          os8_i,
  input  logic          len7_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          stop2_i,
  input  logic          rd_i,
  input  logic          clr_ovr_i,
  output logic [7:0]    data_o,
  output logic          fe_o,
  output logic          pe_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o,
  output logic          ovr_o
);
  logic    rxd_w, fall_w, push_w;
  rx_ent_t ent_w, head_w;
  rx_cfg_t cfg_w;

  assign cfg_w = '{os8: os8_i, len7: len7_i, par_en: par_en_i,
                   par_odd: par_odd_i, stop2: stop2_i};

  rx_os_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .d_i(line_i), .q_o(rxd_w), .fall_o(fall_w)
  );

  rx_os_frame #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_frame (
    .clk_i, .rst_ni, .tick_i, .rxd_i(rxd_w), .fall_i(fall_w),
    .cfg_i(cfg_w), .push_o(push_w), .ent_o(ent_w)
  );

  rx_os_fifo #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_fifo (
    .clk_i, .rst_ni, .push_i(push_w), .ent_i(ent_w), .pop_i(rd_i),
    .clr_ovr_i, .head_o(head_w), .level_o, .ovr_o
  );

  assign data_o  = head_w.data;
  assign fe_o    = head_w.fe;
  assign pe_o    = head_w.pe;
  assign empty_o = (level_o == '0);
endmodule

// File: rtl/rx_os_checker.sv
module rx_os_checker #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          clr_ovr_i,
  input logic          push_i,
  input logic [LW-1:0] level_i,
  input logic          empty_i,
  input logic          ovr_i
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= FULL);  // R7
  AST_LEVEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (int'(level_i) <= int'($past(level_i)) + 1) &&
             (int'(level_i) + 1 >= int'($past(level_i))));  // R7
  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i && rd_i && !push_i |=> empty_i);  // R7
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i && !clr_ovr_i |=> ovr_i);  // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && level_i == FULL && !rd_i |=> ovr_i && level_i == FULL);  // R8
  AST_OVR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_i) |-> $past(push_i) && $past(level_i) == FULL);  // R8
  AST_FULL_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && rd_i && level_i == FULL && !ovr_i |=> level_i == FULL && !ovr_i);  // R9
endmodule

bind rx_os_top rx_os_checker #(.DEPTH(FIFO_DEPTH), .LW(LW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .clr_ovr_i(clr_ovr_i),
  .push_i(push_w), .level_i(level_o), .empty_i(empty_o), .ovr_i(ovr_o)
);

// File: tb/test_rx_os_top.sv
`timescale 1ns/1ps
module test_rx_os_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic line = 1'b1, rd = 1'b0, clr = 1'b0;
  logic os8 = 1'b0, len7 = 1'b0, pen = 1'b0, podd = 1'b0, stop2 = 1'b0;
  logic [1:0] tcnt = '0;
  logic tick;
  logic [7:0] data;
  logic fe, pe, empty, ovr;
  logic [4:0] level;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [7:0] d; logic fe; logic pe; } exp_t;
  exp_t q[$];
  logic exp_ovr = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1'b1;
  assign tick = (tcnt == 2'd3);

  rx_os_top i_rx_os_top (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .tick_i(tick), .os8_i(os8),
    .len7_i(len7), .par_en_i(pen), .par_odd_i(podd), .stop2_i(stop2),
    .rd_i(rd), .clr_ovr_i(clr), .data_o(data), .fe_o(fe), .pe_o(pe),
    .empty_o(empty), .level_o(level), .ovr_o(ovr)
  );

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic align();
    do begin @(posedge clk); #1; end while (tcnt != 2'd0);
  endtask

  function automatic int bit_clks(logic o8); return o8 ? 32 : 64; endfunction
  function automatic int mid_clks(logic o8); return o8 ? 16 : 32; endfunction

  function automatic exp_t model(logic [7:0] d, logic l7, logic pn, bit bp, int bs);
    exp_t e;
    e.d  = l7 ? {1'b0, d[6:0]} : d;
    e.pe = pn & bp;
    e.fe = (bs != 0);
    return e;
  endfunction

  function automatic void model_push(exp_t e);
    if (q.size() < 16) q.push_back(e);
    else exp_ovr = 1'b1;
  endfunction

  // Drives one frame; cfg pins set before alignment, line changes right after a tick edge
  task automatic send(logic [7:0] d, logic c8, logic c7, logic cp, logic co, logic cs,
                      bit bad_par, int bad_stop);
    int bl = bit_clks(c8);
    int nb = c7 ? 7 : 8;
    logic pb;
    os8 = c8; len7 = c7; pen = cp; podd = co; stop2 = cs;
    pb = (c7 ? ^d[6:0] : ^d) ^ co ^ bad_par;
    align();
    line = 1'b0; clks(bl);
    for (int i = 0; i < nb; i++) begin line = d[i]; clks(bl); end
    if (cp) begin line = pb; clks(bl); end
    line = (bad_stop != 1); clks(bl);
    if (cs) begin line = (bad_stop != 2); clks(bl); end
    line = 1'b1; clks(bl);
  endtask

  task automatic pop_check(string req);
    exp_t e = q.pop_front();
    chk(req, int'(empty), 0, "empty before pop");
    chk(req, int'(data), int'(e.d), "data");
    chk("R6", int'(fe), int'(e.fe), "fe");
    chk("R5", int'(pe), int'(e.pe), "pe");
    rd = 1'b1; @(posedge clk); #1; rd = 1'b0;
  endtask

  task automatic drain(string req);
    while (q.size() > 0) pop_check(req);
    chk(req, int'(level), 0, "level after drain");
  endtask

  initial begin
    #(20ns * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clks(3);
    // R1 reset state
    chk("R1", int'(empty), 1, "empty"); chk("R1", int'(level), 0, "level");
    chk("R1", int'(ovr), 0, "ovr");
    rst_n = 1'b1; clks(4);
    chk("R1", int'(empty), 1, "empty after release");

    // R2 glitch shorter than half a bit: nothing stored, both ratios
    align(); line = 1'b0; clks(8); line = 1'b1; clks(200);
    chk("R2", int'(level), 0, "level after 16x glitch");
    os8 = 1'b1; align(); line = 1'b0; clks(8); line = 1'b1; clks(100);
    chk("R2", int'(level), 0, "level after 8x glitch");
    // R7 pop on empty ignored
    rd = 1'b1; clks(1); rd = 1'b0;
    chk("R7", int'(level), 0, "level after empty pop");

    // Directed frames: R3 8x, R4 LSB first / 7-bit, R5 odd/even, R6 two stops
    send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0); model_push(model(8'hA5, 1'b0, 1'b0, 0, 0));
    pop_check("R4");
    send(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0); model_push(model(8'h3C, 1'b0, 1'b0, 0, 0));
    pop_check("R3");
    send(8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 0); model_push(model(8'hFF, 1'b1, 1'b1, 0, 0));
    pop_check("R4");
    send(8'h81, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1, 0); model_push(model(8'h81, 1'b0, 1'b1, 1, 0));
    pop_check("R5");
    send(8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 2); model_push(model(8'h55, 1'b0, 1'b0, 0, 2));
    pop_check("R6");

    // R10 config changed mid-frame must not matter
    fork
      send(8'hC3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 0);
      begin clks(200); os8 = 1'b1; len7 = 1'b1; pen = 1'b0; stop2 = 1'b1; end
    join
    model_push(model(8'hC3, 1'b0, 1'b1, 0, 0));
    chk("R10", int'(level), 1, "level");
    pop_check("R10");

    // Random frames with random format and injected errors
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d = 8'($urandom);
      logic c8 = 1'($urandom), c7 = 1'($urandom), cp = 1'($urandom);
      logic co = 1'($urandom), cs = 1'($urandom);
      bit bp = ($urandom % 4) == 0;
      int bs = (($urandom % 6) == 0) ? (cs ? 1 + int'($urandom % 2) : 1) : 0;
      if (!cp) bp = 0;
      send(d, c8, c7, cp, co, cs, bp, bs);
      model_push(model(d, c7, cp, bp, bs));
      chk("R7", int'(level), q.size(), "level after random frame");
      if (($urandom % 3) == 0) drain("R4");
    end
    drain("R7");

    // R8 overrun: fill, one more frame dropped, head unchanged, clear
    for (int k = 0; k < 16; k++) begin
      send(8'(k + 8'h10), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      model_push(model(8'(k + 8'h10), 1'b0, 1'b0, 0, 0));
    end
    chk("R7", int'(level), 16, "level when full");
    send(8'hEE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
    model_push(model(8'hEE, 1'b0, 1'b0, 0, 0));
    chk("R8", int'(ovr), int'(exp_ovr), "ovr after drop");
    chk("R8", int'(level), 16, "level after drop");
    chk("R8", int'(data), 8'h10, "head after drop");
    clr = 1'b1; clks(1); clr = 1'b0;
    chk("R8", int'(ovr), 0, "ovr after clear");
    exp_ovr = 1'b0;

    // R9 pop lands on the push edge of a frame arriving at a full queue
    // push edge = start edge + mid + N*bit + 1 (sync 2, one push register)
    fork
      send(8'h6B, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 0);
      begin
        align();
        repeat (mid_clks(1'b1) + bit_clks(1'b1) * 11) @(posedge clk);
        #1; rd = 1'b1; @(posedge clk); #1; rd = 1'b0;
      end
    join
    void'(q.pop_front());
    model_push(model(8'h6B, 1'b0, 1'b1, 0, 0));
    chk("R9", int'(level), 16, "level after swap");
    chk("R9", int'(ovr), 0, "ovr after swap");
    drain("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule